// File: doc/BRIEF.md
# Double-Buffered Quad DAC Code Bank

This block holds the codes for a four-channel digital-to-analog converter. Every channel has two registers in series. The host side writes a staging register, and a second register drives the converter with its code. A host write uses a plain strobe, a two-bit channel index and a data word. The write lands only in the staging register of the chosen channel and marks that channel as holding fresh data.

A one-bit mode, bit 3 of an 8-bit control word, decides when staged data moves to the converter registers.

- **Pin mode (the reset default):** an external active-low load strobe moves the data. The strobe is synchronised and its falling edge is detected. The strobe must then stay low for a minimum number of clock samples. When it qualifies, every channel with fresh data copies its staged code on the same clock edge, so all the analog outputs move together.
- **Direct mode:** any channel holding fresh data copies it on the cycle after the write.

Channels without fresh data never reload.

Top module: `dacbank_quad`

## Requirements
- R1: After a synchronous reset, all four converter outputs and all four pending flags read zero, and pin mode is selected.
- R2: A host write with `wr_en` high loads `wr_data` into the staging register of channel `ch_sel` and sets pending bit `ch_sel` on the same edge. In pin mode the converter outputs do not change because of it.
- R3: In pin mode, the load strobe is sampled high and then low on `MIN_LOW` (default 2) consecutive clock edges, m to m+MIN_LOW-1. Every pending channel then updates on edge m+MIN_LOW+1, which is three edges after the first low sample at the default. All such channels change together, and their pending bits clear on that edge.
- R4: A channel whose pending bit is clear keeps its converter output when a qualified load occurs.
- R5: A low strobe that is sampled on fewer than `MIN_LOW` consecutive edges causes no transfer. Pending bits stay set.
- R6: One low period causes at most one transfer. Data written while the strobe stays low waits for the next falling edge.
- R7: A strobe that is already low when reset is released is not a falling edge and causes no transfer until it has been seen high.
- R8: Writing the control word with bit 3 clear selects direct mode. A pending channel then copies its staged code on the edge after the write, and the load strobe has no effect.
- R9: When a host write to a channel lands on the same edge as that channel's transfer, the converter takes the previous staged code and the pending bit stays set.
- R10: Switching from pin mode to direct mode transfers every channel that was already pending, one edge after the control write.
- R11: `ch_sel` values 0, 1, 2 and 3 address the channels driving `dac_a`, `dac_b`, `dac_c` and `dac_d` respectively. Bit n of `pend_o` belongs to channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for a staging register |
| ch_sel | input | 2 | Channel index of the host write |
| wr_data | input | DW (12) | Code to stage |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Control word; bit 3 set selects pin mode |
| ld_n | input | 1 | Asynchronous active-low load strobe |
| dac_a | output | DW (12) | Converter code, channel 0 |
| dac_b | output | DW (12) | Converter code, channel 1 |
| dac_c | output | DW (12) | Converter code, channel 2 |
| dac_d | output | DW (12) | Converter code, channel 3 |
| pend_o | output | 4 | Per-channel fresh-data flags |

## Verification
The bench holds the strobe low across reset. A design that loaded on that level would push staged data to the outputs with no edge. It sends a single-sample glitch, which a design without width qualification would treat as a load. It keeps the strobe low while rewriting a channel, where a level-sensitive design would reload a second time. It also places a host write exactly on the transfer edge, where a design that let the transfer clear the flag would lose the newer code. Switching to direct mode with data already pending checks for a stranded channel, and the first-low-sample timing is checked edge by edge to catch a missing or extra synchroniser stage.

// File: rtl/dacbank_pkg.sv
// Package: constants shared by the quad DAC code bank.
// Assumes four channels; the control word layout keeps the pin-mode bit at 3.
package dacbank_pkg;
    localparam int NUM_CH     = 4;
    localparam int CH_IDX_W   = 2;
    localparam int CFG_W      = 8;
    localparam int PINCTL_BIT = 3;
    localparam logic [CFG_W-1:0] CFG_RESET = 8'h08;

    typedef logic [NUM_CH-1:0] ch_mask_t;
endpackage

// File: rtl/dac_ldpin_qual.sv
// Module: dac_ldpin_qual
// Synchronises the active-low load strobe with two flops, detects a
// high-to-low transition and qualifies it by width. Emits a one-cycle
// pulse once the synchronised level has been low for MIN_LOW cycles
// after being high. Assumes MIN_LOW >= 1. The flops reset to low, so a
// strobe that is low out of reset never counts as an edge.
module dac_ldpin_qual #(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_pin_n,
    output logic load_fire
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_LOW);
    localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(MIN_LOW - 1);

    logic meta_q;
    logic sync_q;
    logic [CNT_W-1:0] low_cnt;

    // Two-flop synchroniser for the asynchronous strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= ld_pin_n;
            sync_q <= meta_q;
        end
    end

    // Count low cycles since the last high level; saturate so a long low fires once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= CNT_SAT;
        end else if (sync_q) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_SAT) begin
            low_cnt <= low_cnt + CNT_W'(1);
        end
    end

    assign load_fire = !sync_q && (low_cnt == CNT_HIT);
endmodule

// File: rtl/dac_mode_reg.sv
// Module: dac_mode_reg
// Holds the load-mode bit of the control word. High selects pin-driven
// loading, low selects direct update. Only bit PINCTL_BIT is stored.
module dac_mode_reg
    import dacbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             pin_en
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[CFG_W-1:PINCTL_BIT+1], cfg_wdata[PINCTL_BIT-1:0]};

    // Capture the mode bit on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_en <= CFG_RESET[PINCTL_BIT];
        end else if (cfg_wr_en) begin
            pin_en <= cfg_wdata[PINCTL_BIT];
        end
    end
endmodule

// File: rtl/dac_chan_slot.sv
// Module: dac_chan_slot
// One channel: staging register, converter register and pending flag.
// Transfers when pending and allowed. A write on the transfer edge keeps
// the flag set, so the newer code waits for the next transfer.
module dac_chan_slot #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    input  logic          xfer_ok,
    output logic [DW-1:0] dac_q,
    output logic          pend_q
);
    logic [DW-1:0] hold_q;
    logic          do_xfer;

    assign do_xfer = pend_q && xfer_ok;

    // Staging register written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_hit) begin
            hold_q <= wr_data;
        end
    end

    // Converter register loaded from the staging register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q <= '0;
        end else if (do_xfer) begin
            dac_q <= hold_q;
        end
    end

    // Pending flag: a write sets it and takes priority over a clearing transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wr_hit) begin
            pend_q <= 1'b1;
        end else if (do_xfer) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dacbank_quad.sv
// Module: dacbank_quad
// Top of the double-buffered quad DAC code bank. Decodes host writes to
// a channel and picks the transfer condition from the mode bit (qualified
// strobe pulse or always). Fans out the four converter registers to
// separate buses. Assumes ld_n is asynchronous and the host inputs are
// synchronous to clk.
module dacbank_quad
    import dacbank_pkg::*;
#(
    parameter int DW      = 12,
    parameter int MIN_LOW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CH_IDX_W-1:0] ch_sel,
    input  logic [DW-1:0]       wr_data,
    input  logic                cfg_wr_en,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                ld_n,
    output logic [DW-1:0]       dac_a,
    output logic [DW-1:0]       dac_b,
    output logic [DW-1:0]       dac_c,
    output logic [DW-1:0]       dac_d,
    output logic [NUM_CH-1:0]   pend_o
);
    logic          pin_en;
    logic          load_fire;
    logic          xfer_ok;
    ch_mask_t      wr_hit;
    logic [DW-1:0] dac_arr [NUM_CH];

    dac_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_wdata (cfg_wdata),
        .pin_en    (pin_en)
    );

    dac_ldpin_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_pin_n  (ld_n),
        .load_fire (load_fire)
    );

    // Transfer condition: qualified strobe in pin mode, always in direct mode.
    assign xfer_ok = pin_en ? load_fire : 1'b1;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign wr_hit[c] = wr_en && (ch_sel == CH_IDX_W'(c));

        dac_chan_slot #(.DW(DW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit[c]),
            .wr_data (wr_data),
            .xfer_ok (xfer_ok),
            .dac_q   (dac_arr[c]),
            .pend_q  (pend_o[c])
        );
    end

    assign dac_a = dac_arr[0];
    assign dac_b = dac_arr[1];
    assign dac_c = dac_arr[2];
    assign dac_d = dac_arr[3];
endmodule

// File: rtl/dacbank_quad_chk.sv
// Module: dacbank_quad_chk
// Assertion checker bound to dacbank_quad. It observes the ports plus
// the mode bit and the qualified load pulse.
module dacbank_quad_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    ch_sel,
    input logic          pin_en,
    input logic          load_fire,
    input logic [DW-1:0] dac_a,
    input logic [DW-1:0] dac_b,
    input logic [DW-1:0] dac_c,
    input logic [DW-1:0] dac_d,
    input logic [3:0]    pend_o
);
    logic prev_rst_low = 1'b0;

    // Remember whether the previous edge applied reset.
    always @(posedge clk) begin
        prev_rst_low <= !rst_n;
    end

    // Outputs are zero on the cycle after a reset edge (R1).
    always @(posedge clk) begin
        if (prev_rst_low) begin
            p_reset_zero_r1: assert (dac_a == '0 && dac_b == '0 && dac_c == '0 &&
                                     dac_d == '0 && pend_o == '0 && pin_en)
                else $error("reset state wrong");
        end
    end

    p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pend_o[$past(ch_sel)]);

    p_hold_without_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en && !load_fire) |=> ($stable(dac_a) && $stable(dac_b) &&
                                    $stable(dac_c) && $stable(dac_d)));

    p_single_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> !load_fire);

    p_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en && load_fire && !wr_en) |=> (pend_o == '0));

    p_direct_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_en && !wr_en) |=> (pend_o == '0));
endmodule

bind dacbank_quad dacbank_quad_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .ch_sel    (ch_sel),
    .pin_en    (pin_en),
    .load_fire (load_fire),
    .dac_a     (dac_a),
    .dac_b     (dac_b),
    .dac_c     (dac_c),
    .dac_d     (dac_d),
    .pend_o    (pend_o)
);

// File: tb/dacbank_quad_test.sv
// Bench for dacbank_quad: behavioural reference model compared every cycle,
// plus directed checks with hand-worked expected values.
module dacbank_quad_test;
    localparam int MINL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  ch_sel = '0;
    logic [11:0] wr_data = '0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        ld_n = 1'b0;
    logic [11:0] dac_a, dac_b, dac_c, dac_d;
    logic [3:0]  pend_o;

    int    checks = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_tag = "R1";

    dacbank_quad uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ch_sel(ch_sel), .wr_data(wr_data),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .ld_n(ld_n),
        .dac_a(dac_a), .dac_b(dac_b), .dac_c(dac_c), .dac_d(dac_d), .pend_o(pend_o)
    );

    always #10 clk = ~clk;

    // Reference model state.
    logic [11:0] m_in  [4];
    logic [11:0] m_dac [4];
    logic [3:0]  m_pend;
    bit          m_pin;
    int          hist[$];

    function automatic int pin_at(int j);
        return (j < hist.size()) ? hist[j] : 0;
    endfunction

    // Advance the reference model on every clock edge.
    always @(posedge clk) begin
        bit       fire;
        bit [3:0] xm;
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end
            m_pend = '0;
            m_pin  = 1'b1;
            hist.delete();
        end else begin
            hist.push_front(int'(ld_n));
            fire = (pin_at(MINL + 2) == 1);
            for (int j = 2; j < MINL + 2; j++) if (pin_at(j) != 0) fire = 0;
            xm = m_pin ? (fire ? m_pend : 4'b0) : m_pend;
            for (int c = 0; c < 4; c++) if (xm[c]) begin m_dac[c] = m_in[c]; m_pend[c] = 1'b0; end
            if (wr_en) begin m_in[ch_sel] = wr_data; m_pend[ch_sel] = 1'b1; end
            if (cfg_wr_en) m_pin = cfg_wdata[3];
            if (hist.size() > 16) void'(hist.pop_back());
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the design with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_tag, " model dac_a"}, dac_a, m_dac[0]);
            chk({cur_tag, " model dac_b"}, dac_b, m_dac[1]);
            chk({cur_tag, " model dac_c"}, dac_c, m_dac[2]);
            chk({cur_tag, " model dac_d"}, dac_d, m_dac[3]);
            chk({cur_tag, " model pend"}, pend_o, m_pend);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(int ch, int val);
        wr_en = 1'b1; ch_sel = 2'(ch); wr_data = 12'(val);
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic cfg_wr(int val);
        cfg_wr_en = 1'b1; cfg_wdata = 8'(val);
        tick(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse(int n);
        ld_n = 1'b0;
        tick(n);
        ld_n = 1'b1;
    endtask

    task automatic wrap_up();
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        wrap_up();
    end

    initial begin
        // R1 / R7: reset with the strobe held low.
        tick(3);
        rst_n = 1'b1;
        tick(1);
        cur_tag = "R1";
        chk("R1 dac_a zero", dac_a, 0);
        chk("R1 pend zero", pend_o, 0);

        cur_tag = "R7";
        host_wr(0, 'h123);
        tick(6);
        chk("R7 no load from reset-low strobe", dac_a, 0);
        chk("R7 pend kept", pend_o, 4'b0001);
        ld_n = 1'b1;
        tick(3);

        // R2 / R11: stage the other channels.
        cur_tag = "R2";
        host_wr(1, 'h456);
        host_wr(2, 'h789);
        host_wr(3, 'hABC);
        chk("R2 all pending", pend_o, 4'hF);
        chk("R2 dac_d unchanged", dac_d, 0);

        // R3: exact transfer edge and simultaneity.
        cur_tag = "R3";
        ld_n = 1'b0;
        tick(2);
        ld_n = 1'b1;
        tick(1);
        chk("R3 not before edge m+3", dac_a, 0);
        tick(1);
        chk("R3 R11 dac_a", dac_a, 'h123);
        chk("R3 R11 dac_b", dac_b, 'h456);
        chk("R3 R11 dac_c", dac_c, 'h789);
        chk("R3 R11 dac_d", dac_d, 'hABC);
        chk("R3 pend cleared", pend_o, 0);

        // R4: only the pending channel changes.
        cur_tag = "R4";
        host_wr(1, 'h111);
        pulse(2);
        tick(3);
        chk("R4 dac_b loaded", dac_b, 'h111);
        chk("R4 dac_a kept", dac_a, 'h123);
        chk("R4 dac_c kept", dac_c, 'h789);

        // R5: single-sample glitch is ignored.
        cur_tag = "R5";
        host_wr(2, 'h222);
        pulse(1);
        tick(5);
        chk("R5 glitch ignored", dac_c, 'h789);
        chk("R5 pend kept", pend_o, 4'b0100);
        pulse(2);
        tick(3);
        chk("R5 proper pulse loads", dac_c, 'h222);

        // R6: one transfer per low period.
        cur_tag = "R6";
        host_wr(3, 'h333);
        ld_n = 1'b0;
        tick(5);
        chk("R6 first load", dac_d, 'h333);
        host_wr(3, 'h444);
        tick(5);
        chk("R6 no reload while low", dac_d, 'h333);
        chk("R6 pend set", pend_o, 4'b1000);
        ld_n = 1'b1;
        tick(3);
        pulse(2);
        tick(3);
        chk("R6 next edge loads", dac_d, 'h444);

        // R9: write collides with the transfer edge.
        cur_tag = "R9";
        host_wr(0, 'h555);
        ld_n = 1'b0;
        tick(2);
        ld_n = 1'b1;
        tick(1);
        host_wr(0, 'h666);
        chk("R9 old staged code taken", dac_a, 'h555);
        chk("R9 pend stays set", pend_o, 4'b0001);
        pulse(2);
        tick(3);
        chk("R9 newer code later", dac_a, 'h666);

        // R8: direct mode.
        cur_tag = "R8";
        cfg_wr('h00);
        host_wr(1, 'h777);
        chk("R8 not same edge", dac_b, 'h111);
        tick(1);
        chk("R8 next edge", dac_b, 'h777);
        chk("R8 pend clear", pend_o, 0);
        pulse(2);
        tick(3);
        chk("R8 strobe no effect", dac_b, 'h777);

        // R10: pending data flushes on mode switch.
        cur_tag = "R10";
        cfg_wr('h08);
        host_wr(2, 'hAAA);
        tick(2);
        chk("R10 held in pin mode", dac_c, 'h222);
        cfg_wr('h00);
        chk("R10 not on control edge", dac_c, 'h222);
        tick(1);
        chk("R10 flushed", dac_c, 'hAAA);
        chk("R10 pend clear", pend_o, 0);

        tick(2);
        wrap_up();
    end
endmodule